// File: doc/BRIEF.md
# Prefetching FIFO over Synchronous-Read Storage

This block is a first-in first-out queue whose storage is a two-port memory with one write port and one registered read port. A read returns its data one clock after the address is presented. The block hides that delay, so the oldest stored word is already on the data output whenever the queue holds anything. A consumer can take it in the same cycle it pops, as with a fall-through queue built from flip-flops.

The next read address of a queue is always known, so the block does not wait for a pop to start a read. Each cycle it presents either the current read pointer or, when a pop is accepted, the pointer one entry further on. The head word then sits in the memory's output register one clock later. One case cannot be served from memory: a word that becomes the head in the same cycle it is written. This happens when the queue was empty, or when it held one word that was popped as the new word arrived. For that case a single bypass register captures the written word and drives the output for exactly one cycle. After that, reads stream from memory.

The producer side uses a push strobe, a data word and a full flag. The consumer side uses a pop strobe, the head word and an empty flag. A synchronous flush empties the queue, and an occupancy count is available.

Top module: `prefetch_fifo`

## Requirements
- R1: After reset deasserts, count_o is 0, empty_o is 1 and full_o is 0.
- R2: Whenever empty_o is 0, rdata_o carries the oldest stored word without any pop being required, and it stays unchanged until a pop or flush is accepted.
- R3: Words leave in exactly the order they were accepted, across any mix of push and pop cycles, including wrap-around of the storage.
- R4: A word pushed into an empty queue appears on rdata_o in the next cycle, and a pop in that next cycle consumes it.
- R5: A push while full_o is 1 is ignored, including when a pop is accepted in the same cycle: the word is not stored and, with no pop, count_o and rdata_o are unchanged.
- R6: A pop while empty_o is 1 is ignored, and count_o stays 0.
- R7: A push and a pop accepted together leave count_o unchanged. When count_o was 1, the pushed word is on rdata_o in the next cycle.
- R8: count_o equals the number of stored words and changes by at most one per cycle outside flush. full_o is 1 exactly when count_o equals DEPTH, and empty_o is 1 exactly when count_o is 0.
- R9: flush_i empties the queue in one cycle (count_o becomes 0), and any push or pop in the flush cycle is ignored.
- R10: Popping in every cycle from a full queue delivers one stored word per cycle, in order, with no gap cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Synchronous discard of all stored words |
| push_i | input | 1 | Write strobe |
| wdata_i | input | DATA_W | Word to store |
| full_o | output | 1 | Queue holds DEPTH words |
| pop_i | input | 1 | Consume the head word |
| rdata_o | output | DATA_W | Head word, valid while empty_o is 0 |
| empty_o | output | 1 | Queue holds no words |
| count_o | output | $clog2(DEPTH+1) | Number of stored words |

## Verification
The properties assume push_i, pop_i and flush_i are known (0 or 1) on every sampled clock edge once reset has been released. They also assume that rdata_o is only compared while the queue is non-empty, because the output is undefined when nothing is stored. The stimulus drives all three strobes to defined levels from reset onward, changes them only on falling edges, and mixes in pushes on a full queue and pops on an empty one on purpose. Checks against a reference queue compare head data only when that queue holds a word.

// File: rtl/prefetch_fifo_pkg.sv
package prefetch_fifo_pkg;

   // Index width that never collapses to zero for single-entry structures.
   function automatic int unsigned idx_width(input int unsigned entries);
      return (entries > 1) ? $clog2(entries) : 1;
   endfunction

   // Which path feeds the head word this cycle.
   typedef enum logic {
      HEAD_FROM_RAM = 1'b0,
      HEAD_FROM_AUX = 1'b1
   } head_src_e;

endpackage

// File: rtl/sync_ram_2p.sv
module sync_ram_2p #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 8,
   localparam int unsigned AW    = prefetch_fifo_pkg::idx_width(DEPTH)
) (
   input  logic              clk_i,
   input  logic              wr_en_i,
   input  logic [AW-1:0]     wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [AW-1:0]     rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o
);

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [DATA_W-1:0] rd_q;

   // Write port: one word per cycle.
   always_ff @(posedge clk_i) begin
      if (wr_en_i) begin
         mem_q[wr_addr_i] <= wr_data_i;
      end
   end

   // Registered read port: the word appears one clock after its address.
   // A read and a write to the same address return the old contents.
   always_ff @(posedge clk_i) begin
      rd_q <= mem_q[rd_addr_i];
   end

   assign rd_data_o = rd_q;

endmodule

// File: rtl/fifo_ptr_ctrl.sv
module fifo_ptr_ctrl #(
   parameter int unsigned DEPTH  = 8,
   localparam int unsigned AW    = prefetch_fifo_pkg::idx_width(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             flush_i,
   input  logic             push_req_i,
   input  logic             pop_req_i,
   output logic             push_ok_o,
   output logic             pop_ok_o,
   output logic [AW-1:0]    wr_ptr_o,
   output logic [AW-1:0]    rd_addr_o,
   output logic [CNT_W-1:0] count_o,
   output logic             full_o,
   output logic             empty_o
);

   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
   localparam logic [AW-1:0]    PTR_LAST = AW'(DEPTH - 1);
   localparam bit               IS_POW2  = ((DEPTH & (DEPTH - 1)) == 0);

   logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
   logic [AW-1:0]    wr_ptr_inc, rd_ptr_inc;
   logic [CNT_W-1:0] count_q, count_d;

   // Pointer advance: a power-of-two depth wraps by overflow, any other
   // depth needs an explicit compare against the last index.
   generate
      if (IS_POW2) begin : g_wrap_natural
         always_comb begin
            wr_ptr_inc = wr_ptr_q + 1'b1;
            rd_ptr_inc = rd_ptr_q + 1'b1;
         end
      end else begin : g_wrap_compare
         always_comb begin
            wr_ptr_inc = (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
            rd_ptr_inc = (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
         end
      end
   endgenerate

   assign full_o    = (count_q == CNT_FULL);
   assign empty_o   = (count_q == '0);
   assign push_ok_o = push_req_i && !full_o && !flush_i;
   assign pop_ok_o  = pop_req_i && !empty_o && !flush_i;

   // The address is always known ahead: after a pop it is the following slot.
   assign rd_addr_o = pop_ok_o ? rd_ptr_inc : rd_ptr_q;

   always_comb begin
      count_d = count_q;
      unique case ({push_ok_o, pop_ok_o})
         2'b10:   count_d = count_q + 1'b1;
         2'b01:   count_d = count_q - 1'b1;
         default: count_d = count_q;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count_q  <= '0;
      end else if (flush_i) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         count_q  <= '0;
      end else begin
         if (push_ok_o) wr_ptr_q <= wr_ptr_inc;
         if (pop_ok_o)  rd_ptr_q <= rd_ptr_inc;
         count_q <= count_d;
      end
   end

   assign wr_ptr_o = wr_ptr_q;
   assign count_o  = count_q;

endmodule

// File: rtl/head_bypass.sv
module head_bypass #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 8,
   localparam int unsigned AW    = prefetch_fifo_pkg::idx_width(DEPTH)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              flush_i,
   input  logic              push_ok_i,
   input  logic [AW-1:0]     wr_ptr_i,
   input  logic [AW-1:0]     rd_addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic [DATA_W-1:0] ram_data_i,
   output logic [DATA_W-1:0] head_o
);

   import prefetch_fifo_pkg::*;

   logic              aux_load;
   logic [DATA_W-1:0] aux_q;
   head_src_e         src_q;

   // The word written this cycle is also the one being fetched: memory
   // would return stale contents, so keep a private copy for one cycle.
   assign aux_load = push_ok_i && (wr_ptr_i == rd_addr_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         src_q <= HEAD_FROM_RAM;
      end else if (flush_i) begin
         src_q <= HEAD_FROM_RAM;
      end else begin
         src_q <= aux_load ? HEAD_FROM_AUX : HEAD_FROM_RAM;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         aux_q <= '0;
      end else if (aux_load) begin
         aux_q <= wdata_i;
      end
   end

   always_comb begin
      unique case (src_q)
         HEAD_FROM_AUX: head_o = aux_q;
         default:       head_o = ram_data_i;
      endcase
   end

endmodule

// File: rtl/prefetch_fifo.sv
module prefetch_fifo #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 8,
   localparam int unsigned AW    = prefetch_fifo_pkg::idx_width(DEPTH),
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              flush_i,
   input  logic              push_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic              full_o,
   input  logic              pop_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              empty_o,
   output logic [CNT_W-1:0]  count_o
);

   // Elaboration-time parameter checks.
   if (DEPTH < 2) begin : g_bad_depth
      $error("prefetch_fifo: DEPTH must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("prefetch_fifo: DATA_W must be at least 1");
   end

   logic              push_ok, pop_ok;
   logic [AW-1:0]     wr_ptr, rd_addr;
   logic [DATA_W-1:0] ram_rdata;

   fifo_ptr_ctrl #(
      .DEPTH (DEPTH)
   ) u_ctrl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .flush_i    (flush_i),
      .push_req_i (push_i),
      .pop_req_i  (pop_i),
      .push_ok_o  (push_ok),
      .pop_ok_o   (pop_ok),
      .wr_ptr_o   (wr_ptr),
      .rd_addr_o  (rd_addr),
      .count_o    (count_o),
      .full_o     (full_o),
      .empty_o    (empty_o)
   );

   sync_ram_2p #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_ram (
      .clk_i     (clk_i),
      .wr_en_i   (push_ok),
      .wr_addr_i (wr_ptr),
      .wr_data_i (wdata_i),
      .rd_addr_i (rd_addr),
      .rd_data_o (ram_rdata)
   );

   head_bypass #(
      .DATA_W (DATA_W),
      .DEPTH  (DEPTH)
   ) u_head (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .flush_i    (flush_i),
      .push_ok_i  (push_ok),
      .wr_ptr_i   (wr_ptr),
      .rd_addr_i  (rd_addr),
      .wdata_i    (wdata_i),
      .ram_data_i (ram_rdata),
      .head_o     (rdata_o)
   );

endmodule

// File: rtl/prefetch_fifo_chk.sv
module prefetch_fifo_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 8,
   localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              flush_i,
   input logic              push_i,
   input logic [DATA_W-1:0] wdata_i,
   input logic              full_o,
   input logic              pop_i,
   input logic [DATA_W-1:0] rdata_o,
   input logic              empty_o,
   input logic [CNT_W-1:0]  count_o
);

   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

   assert_flush_empties_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      flush_i |=> (count_o == '0 && empty_o));

   assert_no_overflow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (full_o && push_i && !pop_i && !flush_i) |=> (count_o == CNT_FULL && $stable(rdata_o)));

   assert_no_underflow_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (empty_o && pop_i && !push_i && !flush_i) |=> (empty_o && count_o == '0));

   assert_pushpop_count_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (push_i && pop_i && !empty_o && !full_o && !flush_i) |=> $stable(count_o));

   assert_refill_head_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (count_o == CNT_W'(1) && push_i && pop_i && !flush_i) |=> (rdata_o == $past(wdata_i)));

   assert_first_word_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (empty_o && push_i && !flush_i) |=> (!empty_o && rdata_o == $past(wdata_i)));

   assert_head_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!empty_o && !pop_i && !flush_i) |=> $stable(rdata_o));

   assert_count_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !flush_i |=> (count_o == $past(count_o) || count_o == $past(count_o) + 1'b1
                    || count_o == $past(count_o) - 1'b1));

   assert_count_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      count_o <= CNT_FULL);

endmodule

bind prefetch_fifo prefetch_fifo_chk #(
   .DATA_W (DATA_W),
   .DEPTH  (DEPTH)
) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .flush_i (flush_i),
   .push_i  (push_i),
   .wdata_i (wdata_i),
   .full_o  (full_o),
   .pop_i   (pop_i),
   .rdata_o (rdata_o),
   .empty_o (empty_o),
   .count_o (count_o)
);

// File: tb/sim_prefetch_fifo.sv
`timescale 1ns/1ps
module sim_prefetch_fifo;

   localparam int unsigned DW    = 16;
   localparam int unsigned DEP   = 4;
   localparam int unsigned CW    = $clog2(DEP + 1);
   localparam int unsigned NVEC  = 19;

   typedef struct packed {
      logic          push;
      logic          pop;
      logic          flush;
      logic [DW-1:0] wd;
      logic [CW-1:0] cnt;
      logic [DW-1:0] head;
   } vec_t;

   // Each row: inputs for one cycle, expected state after that clock edge.
   localparam vec_t VEC [NVEC] = '{
      '{1'b1, 1'b0, 1'b0, 16'hA001, 3'd1, 16'hA001}, // R4 push into empty
      '{1'b0, 1'b1, 1'b0, 16'h0000, 3'd0, 16'h0000}, // R4 pop next cycle
      '{1'b0, 1'b1, 1'b0, 16'h0000, 3'd0, 16'h0000}, // R6 pop while empty
      '{1'b1, 1'b0, 1'b0, 16'hB001, 3'd1, 16'hB001},
      '{1'b1, 1'b0, 1'b0, 16'hB002, 3'd2, 16'hB001},
      '{1'b1, 1'b1, 1'b0, 16'hB003, 3'd2, 16'hB002}, // R7
      '{1'b1, 1'b0, 1'b0, 16'hB004, 3'd3, 16'hB002},
      '{1'b1, 1'b0, 1'b0, 16'hB005, 3'd4, 16'hB002}, // R8 full
      '{1'b1, 1'b0, 1'b0, 16'hB006, 3'd4, 16'hB002}, // R5 push while full
      '{1'b0, 1'b1, 1'b0, 16'h0000, 3'd3, 16'hB003},
      '{1'b0, 1'b1, 1'b0, 16'h0000, 3'd2, 16'hB004},
      '{1'b0, 1'b1, 1'b0, 16'h0000, 3'd1, 16'hB005},
      '{1'b1, 1'b1, 1'b0, 16'hC001, 3'd1, 16'hC001}, // R7 refill at count 1
      '{1'b0, 1'b1, 1'b0, 16'h0000, 3'd0, 16'h0000},
      '{1'b1, 1'b0, 1'b0, 16'hD001, 3'd1, 16'hD001},
      '{1'b1, 1'b0, 1'b0, 16'hD002, 3'd2, 16'hD001},
      '{1'b1, 1'b1, 1'b1, 16'hD003, 3'd0, 16'h0000}, // R9 flush beats push/pop
      '{1'b1, 1'b0, 1'b0, 16'hE001, 3'd1, 16'hE001},
      '{1'b0, 1'b1, 1'b0, 16'h0000, 3'd0, 16'h0000}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          flush = 1'b0;
   logic          push = 1'b0;
   logic          pop = 1'b0;
   logic [DW-1:0] wdata = '0;
   logic          full, empty;
   logic [DW-1:0] rdata;
   logic [CW-1:0] count;

   int n_checks = 0;
   int n_err    = 0;

   logic [DW-1:0] model_q [$];

   always #2.5 clk = ~clk;

   prefetch_fifo #(
      .DATA_W (DW),
      .DEPTH  (DEP)
   ) u0 (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .flush_i (flush),
      .push_i  (push),
      .wdata_i (wdata),
      .full_o  (full),
      .pop_i   (pop),
      .rdata_o (rdata),
      .empty_o (empty),
      .count_o (count)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step(input logic p, input logic q, input logic f, input logic [DW-1:0] d);
      @(negedge clk);
      push  = p;
      pop   = q;
      flush = f;
      wdata = d;
      @(posedge clk);
      #1;
   endtask

   task automatic check_state(input string tag, input int exp_cnt);
      check({tag, " R8 count"}, 32'(count), 32'(exp_cnt));
      check({tag, " R8 empty"}, 32'(empty), 32'(exp_cnt == 0));
      check({tag, " R8 full"},  32'(full),  32'(exp_cnt == DEP));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      n_err++;
      $display("FAIL R3 watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      check("R1 count after reset", 32'(count), 32'd0);
      check("R1 empty after reset", 32'(empty), 32'd1);
      check("R1 full after reset",  32'(full),  32'd0);

      // Vector table walk
      for (int i = 0; i < NVEC; i++) begin
         step(VEC[i].push, VEC[i].pop, VEC[i].flush, VEC[i].wd);
         check_state($sformatf("table row %0d", i), int'(VEC[i].cnt));
         if (VEC[i].cnt != '0) begin
            check($sformatf("R3 table row %0d head", i), 32'(rdata), 32'(VEC[i].head));
         end
      end

      // R2: head visible and held without pops
      step(1'b1, 1'b0, 1'b0, 16'h1111);
      for (int k = 0; k < 3; k++) begin
         step(1'b0, 1'b0, 1'b0, 16'h0000);
         check("R2 head held while idle", 32'(rdata), 32'h1111);
      end
      step(1'b1, 1'b0, 1'b0, 16'h2222);
      check("R2 head unchanged by later push", 32'(rdata), 32'h1111);

      // R9 flush with contents present
      step(1'b0, 1'b0, 1'b1, 16'h0000);
      check_state("R9 flush", 0);

      // R10 fill then pop every cycle
      for (int k = 0; k < DEP; k++) begin
         step(1'b1, 1'b0, 1'b0, DW'(16'h5000 + k));
      end
      check_state("R10 filled", DEP);
      check("R10 first head", 32'(rdata), 32'h5000);
      // R5 push alongside a pop on a full queue is refused
      step(1'b1, 1'b1, 1'b0, 16'h5FFF);
      check_state("R5 push with pop when full", DEP - 1);
      check("R10 head after pop 0", 32'(rdata), 32'h5001);
      for (int k = 1; k < DEP; k++) begin
         step(1'b0, 1'b1, 1'b0, 16'h0000);
         check_state($sformatf("R10 pop %0d", k), DEP - 1 - k);
         if (k < DEP - 1) begin
            check($sformatf("R10 head after pop %0d", k), 32'(rdata), 32'(16'h5001 + k));
         end
      end

      // R3 random traffic against a reference queue
      model_q.delete();
      for (int c = 0; c < 3000; c++) begin
         logic          p, q, f;
         logic [DW-1:0] d;
         p = 1'($urandom % 2);
         q = 1'($urandom % 2);
         f = (($urandom % 97) == 0);
         d = DW'($urandom);
         if (f) begin
            model_q.delete();
         end else begin
            logic can_push, can_pop;
            can_push = p && (model_q.size() < DEP);
            can_pop  = q && (model_q.size() > 0);
            if (can_pop)  void'(model_q.pop_front());
            if (can_push) model_q.push_back(d);
         end
         step(p, q, f, d);
         check("R3 random count", 32'(count), 32'(model_q.size()));
         if (model_q.size() > 0) begin
            check("R3 random head order", 32'(rdata), 32'(model_q[0]));
         end
      end

      // R1 reset in the middle of traffic
      step(1'b1, 1'b0, 1'b0, 16'h7777);
      @(negedge clk);
      push  = 1'b0;
      rst_n = 1'b0;
      #1;
      check("R1 count during reset", 32'(count), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 empty after second reset", 32'(empty), 32'd1);

      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

endmodule